// File: doc/BRIEF.md
# Link Active/Idle Toggling Controller

This block saves energy on an Ethernet-style link by letting each direction run at full rate only while it has work, then drop into a quiet low-power idle. It sits between the host-side transmit buffer and a simplified PHY-facing interface. The transmit and receive sides each have their own state machine, so one direction can sleep while the other carries traffic.

On transmit, the block watches the buffer fill level. When the level reaches a programmable threshold, it turns the PHY transmit path on. It then sends a one-cycle start-transmit marker toward the link partner and counts a resume delay before it accepts payload. When the buffer stays empty for a hold-off window, the block turns the PHY transmit path off and waits a short entry delay before it reports idle. A driver-controlled force input overrides the threshold policy.

On receive, the block follows the link partner. A received start-transmit marker wakes the receive side, and a detected idle signal puts it back to sleep. Received beats reach the controller only while the receive side is active. All delays are cycle-count parameters.

Top module: `link_toggle_ctrl`

## Requirements
- R1: A synchronous reset makes both directions idle on the next edge: tx_state=0, rx_state=0, host_ready=0, phy_tx_on=0, phy_tx_marker=0, phy_tx_valid=0, ctrl_rx_valid=0.
- R2: tx_state encodes 0 idle, 1 resuming, 2 active, 3 hold-off, 4 entering idle. From idle, the transmit side moves to resuming on the next edge when fill_level is nonzero and at least fill_thresh. A lower level leaves it idle.
- R3: phy_tx_on is high in states 1, 2 and 3 and low in 0 and 4. phy_tx_marker pulses for exactly one cycle, the second cycle of resuming. The active state follows after RESUME_CYC cycles of resuming.
- R4: host_ready is high only in the active state. A beat with host_valid and host_ready high appears on phy_tx_valid/phy_tx_data one cycle later. No beat leaves in any other state.
- R5: In the active state, an empty buffer with force_active low enters hold-off. WAIT_CYC consecutive empty cycles lead to entering idle. A nonzero fill level during hold-off, including its last cycle, returns to active on the next edge.
- R6: Entering idle lasts SLEEP_CYC cycles and then reaches idle, whatever the fill level does meanwhile. A pending wake condition then starts a normal resume on the following edge.
- R7: force_active high wakes the transmit side from idle and keeps it active with an empty buffer. It does not cut short the entering-idle delay.
- R8: rx_state (0 idle, 1 active) goes to 1 on the edge after phy_rx_marker is seen while idle. It goes to 0 on the edge after phy_rx_idle_det is seen while active.
- R9: A received beat (phy_rx_valid) is passed to ctrl_rx_valid/ctrl_rx_data one cycle later only if rx_state was 1 in its cycle. Otherwise it is dropped.
- R10: The receive state changes regardless of the transmit state, and the transmit state changes regardless of the receive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | LVL_W | Pending transmit data in the host buffer |
| fill_thresh | input | LVL_W | Fill level that wakes the transmit side |
| force_active | input | 1 | Driver override that keeps transmit active |
| host_valid | input | 1 | Host transmit beat valid |
| host_data | input | DW | Host transmit beat |
| host_ready | output | 1 | Transmit side accepts a beat |
| phy_tx_on | output | 1 | PHY transmit path powered and running |
| phy_tx_marker | output | 1 | One-cycle start-transmit marker to the partner |
| phy_tx_valid | output | 1 | Transmit beat valid toward the PHY |
| phy_tx_data | output | DW | Transmit beat toward the PHY |
| phy_rx_marker | input | 1 | Start-transmit marker received from the partner |
| phy_rx_idle_det | input | 1 | PHY reports the partner's idle signal |
| phy_rx_valid | input | 1 | Received beat valid |
| phy_rx_data | input | DW | Received beat |
| ctrl_rx_valid | output | 1 | Received beat valid toward the controller |
| ctrl_rx_data | output | DW | Received beat toward the controller |
| tx_state | output | 3 | Transmit state code |
| rx_state | output | 1 | Receive state code |

## Verification
The critical same-cycle collision is the last cycle of the transmit hold-off meeting the arrival of new data. Expiry would start the sleep, while arrival must win and keep the path active. The bench parks the hold-off counter on its final cycle, raises the fill level exactly there, and expects state 2 rather than 4 after the edge. A second collision puts a received wake marker and new transmit data into the entering-idle window together. The receive side must wake at once, and the transmit side must finish sleeping before it resumes.

// File: rtl/link_toggle_pkg.sv
package link_toggle_pkg;
  typedef enum logic [2:0] {
    TX_IDLE    = 3'd0,
    TX_RESUME  = 3'd1,
    TX_ACTIVE  = 3'd2,
    TX_HOLDOFF = 3'd3,
    TX_ENTRY   = 3'd4
  } tx_st_e;

  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_st_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/link_toggle_dcnt.sv
module link_toggle_dcnt #(
  parameter int LIMIT = 4,
  parameter int W     = link_toggle_pkg::cnt_w(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  output logic         zero,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst)                        count <= '0;
    else if (load)                  count <= TOP;
    else if (dec && count != '0)    count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/link_toggle_tx.sv
module link_toggle_tx
  import link_toggle_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int DW         = 8,
  parameter int RESUME_CYC = 1250,
  parameter int WAIT_CYC   = 1250,
  parameter int SLEEP_CYC  = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic             force_active,
  input  logic             host_valid,
  input  logic [DW-1:0]    host_data,
  output logic             host_ready,
  output logic             phy_tx_on,
  output logic             phy_tx_marker,
  output logic             phy_tx_valid,
  output logic [DW-1:0]    phy_tx_data,
  output logic [2:0]       tx_state
);
  localparam int RW = cnt_w(RESUME_CYC);
  localparam int HW = cnt_w(WAIT_CYC);
  localparam int SW = cnt_w(SLEEP_CYC);
  localparam logic [RW-1:0] RES_FIRST = RW'(RESUME_CYC - 1);

  tx_st_e state_q, state_d;
  logic   wake_req, empty;
  logic   res_load, res_dec, res_zero;
  logic   hold_load, hold_dec, hold_zero;
  logic   slp_load, slp_dec, slp_zero;
  logic [RW-1:0] res_cnt;
  logic [HW-1:0] hold_cnt;
  logic [SW-1:0] slp_cnt;

  assign empty    = (fill_level == '0);
  assign wake_req = force_active || (!empty && fill_level >= fill_thresh);

  assign res_load  = (state_q == TX_IDLE) && wake_req;
  assign res_dec   = (state_q == TX_RESUME);
  assign hold_load = (state_q == TX_ACTIVE) && empty && !force_active;
  assign hold_dec  = (state_q == TX_HOLDOFF);
  assign slp_load  = (state_q == TX_HOLDOFF) && hold_zero && empty && !force_active;
  assign slp_dec   = (state_q == TX_ENTRY);

  link_toggle_dcnt #(.LIMIT(RESUME_CYC), .W(RW)) u_res_cnt (
    .clk(clk), .rst(rst), .load(res_load), .dec(res_dec),
    .zero(res_zero), .count(res_cnt)
  );

  link_toggle_dcnt #(.LIMIT(WAIT_CYC), .W(HW)) u_hold_cnt (
    .clk(clk), .rst(rst), .load(hold_load), .dec(hold_dec),
    .zero(hold_zero), .count(hold_cnt)
  );

  link_toggle_dcnt #(.LIMIT(SLEEP_CYC), .W(SW)) u_slp_cnt (
    .clk(clk), .rst(rst), .load(slp_load), .dec(slp_dec),
    .zero(slp_zero), .count(slp_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:    if (wake_req) state_d = TX_RESUME;
      TX_RESUME:  if (res_zero) state_d = TX_ACTIVE;
      TX_ACTIVE:  if (empty && !force_active) state_d = TX_HOLDOFF;
      TX_HOLDOFF: begin
        if (!empty || force_active) state_d = TX_ACTIVE;
        else if (hold_zero)         state_d = TX_ENTRY;
      end
      TX_ENTRY:   if (slp_zero) state_d = TX_IDLE;
      default:    state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= TX_IDLE;
      phy_tx_marker <= 1'b0;
      phy_tx_valid  <= 1'b0;
      phy_tx_data   <= '0;
    end else begin
      state_q       <= state_d;
      phy_tx_marker <= (state_q == TX_RESUME) && (res_cnt == RES_FIRST);
      phy_tx_valid  <= host_valid && (state_q == TX_ACTIVE);
      if (host_valid && state_q == TX_ACTIVE) phy_tx_data <= host_data;
    end
  end

  assign host_ready = (state_q == TX_ACTIVE);
  assign phy_tx_on  = (state_q == TX_RESUME) || (state_q == TX_ACTIVE) ||
                      (state_q == TX_HOLDOFF);
  assign tx_state   = state_q;

  logic unused_cnt;
  assign unused_cnt = ^{hold_cnt, slp_cnt};
endmodule

// File: rtl/link_toggle_rx.sv
module link_toggle_rx
  import link_toggle_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phy_rx_marker,
  input  logic          phy_rx_idle_det,
  input  logic          phy_rx_valid,
  input  logic [DW-1:0] phy_rx_data,
  output logic          ctrl_rx_valid,
  output logic [DW-1:0] ctrl_rx_data,
  output logic          rx_state
);
  rx_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE:   if (phy_rx_marker)   state_d = RX_ACTIVE;
      RX_ACTIVE: if (phy_rx_idle_det) state_d = RX_IDLE;
      default:   state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= RX_IDLE;
      ctrl_rx_valid <= 1'b0;
      ctrl_rx_data  <= '0;
    end else begin
      state_q       <= state_d;
      ctrl_rx_valid <= phy_rx_valid && (state_q == RX_ACTIVE);
      if (phy_rx_valid && state_q == RX_ACTIVE) ctrl_rx_data <= phy_rx_data;
    end
  end

  assign rx_state = state_q;
endmodule

// File: rtl/link_toggle_ctrl.sv
module link_toggle_ctrl #(
  parameter int LVL_W      = 6,
  parameter int DW         = 8,
  parameter int RESUME_CYC = 1250,
  parameter int WAIT_CYC   = 1250,
  parameter int SLEEP_CYC  = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic             force_active,
  input  logic             host_valid,
  input  logic [DW-1:0]    host_data,
  output logic             host_ready,
  output logic             phy_tx_on,
  output logic             phy_tx_marker,
  output logic             phy_tx_valid,
  output logic [DW-1:0]    phy_tx_data,
  input  logic             phy_rx_marker,
  input  logic             phy_rx_idle_det,
  input  logic             phy_rx_valid,
  input  logic [DW-1:0]    phy_rx_data,
  output logic             ctrl_rx_valid,
  output logic [DW-1:0]    ctrl_rx_data,
  output logic [2:0]       tx_state,
  output logic             rx_state
);
  // RESUME_CYC must be at least 2 so the marker lands inside the resume window.
  link_toggle_tx #(
    .LVL_W(LVL_W), .DW(DW), .RESUME_CYC(RESUME_CYC),
    .WAIT_CYC(WAIT_CYC), .SLEEP_CYC(SLEEP_CYC)
  ) u_tx (
    .clk(clk), .rst(rst), .fill_level(fill_level), .fill_thresh(fill_thresh),
    .force_active(force_active), .host_valid(host_valid), .host_data(host_data),
    .host_ready(host_ready), .phy_tx_on(phy_tx_on), .phy_tx_marker(phy_tx_marker),
    .phy_tx_valid(phy_tx_valid), .phy_tx_data(phy_tx_data), .tx_state(tx_state)
  );

  link_toggle_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .phy_rx_marker(phy_rx_marker),
    .phy_rx_idle_det(phy_rx_idle_det), .phy_rx_valid(phy_rx_valid),
    .phy_rx_data(phy_rx_data), .ctrl_rx_valid(ctrl_rx_valid),
    .ctrl_rx_data(ctrl_rx_data), .rx_state(rx_state)
  );
endmodule

// File: rtl/link_toggle_chk.sv
module link_toggle_chk #(
  parameter int LVL_W = 6,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fill_level,
  input logic [LVL_W-1:0] fill_thresh,
  input logic             force_active,
  input logic             host_valid,
  input logic             host_ready,
  input logic             phy_tx_on,
  input logic             phy_tx_marker,
  input logic             phy_tx_valid,
  input logic             phy_rx_marker,
  input logic             phy_rx_valid,
  input logic             ctrl_rx_valid,
  input logic [2:0]       tx_state,
  input logic             rx_state
);
  logic wake_cond;
  assign wake_cond = force_active || (fill_level != '0 && fill_level >= fill_thresh);

  a_r2_wake_from_idle: assert property (@(posedge clk) disable iff (rst)
    (tx_state == 3'd0 && wake_cond) |=> tx_state == 3'd1);

  a_r3_marker_in_resume: assert property (@(posedge clk) disable iff (rst)
    phy_tx_marker |-> (tx_state == 3'd1 && $past(tx_state) == 3'd1));

  a_r3_phy_on_states: assert property (@(posedge clk) disable iff (rst)
    (tx_state == 3'd0 || tx_state == 3'd4) |-> !phy_tx_on);

  a_r4_ready_only_active: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> tx_state == 3'd2);

  a_r4_beat_needs_fire: assert property (@(posedge clk) disable iff (rst)
    phy_tx_valid |-> $past(host_valid && host_ready));

  a_r5_holdoff_return: assert property (@(posedge clk) disable iff (rst)
    (tx_state == 3'd3 && fill_level != '0) |=> tx_state == 3'd2);

  a_r8_rx_wake: assert property (@(posedge clk) disable iff (rst)
    (rx_state == 1'b0 && phy_rx_marker) |=> rx_state == 1'b1);

  a_r9_rx_gate: assert property (@(posedge clk) disable iff (rst)
    ctrl_rx_valid |-> $past(rx_state == 1'b1 && phy_rx_valid));
endmodule

bind link_toggle_ctrl link_toggle_chk #(.LVL_W(LVL_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .fill_level(fill_level), .fill_thresh(fill_thresh),
  .force_active(force_active), .host_valid(host_valid), .host_ready(host_ready),
  .phy_tx_on(phy_tx_on), .phy_tx_marker(phy_tx_marker), .phy_tx_valid(phy_tx_valid),
  .phy_rx_marker(phy_rx_marker), .phy_rx_valid(phy_rx_valid),
  .ctrl_rx_valid(ctrl_rx_valid), .tx_state(tx_state), .rx_state(rx_state)
);

// File: tb/link_toggle_ctrl_tb.sv
`timescale 1ns/1ps
module link_toggle_ctrl_tb;
  localparam int LVL_W = 6;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LVL_W-1:0] fill_level = '0, fill_thresh = 6'd4;
  logic force_active = 1'b0, host_valid = 1'b0;
  logic [DW-1:0] host_data = '0, phy_rx_data = '0;
  logic phy_rx_marker = 1'b0, phy_rx_idle_det = 1'b0, phy_rx_valid = 1'b0;
  logic host_ready, phy_tx_on, phy_tx_marker, phy_tx_valid, ctrl_rx_valid, rx_state;
  logic [DW-1:0] phy_tx_data, ctrl_rx_data;
  logic [2:0] tx_state;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_toggle_ctrl #(.LVL_W(LVL_W), .DW(DW), .RESUME_CYC(4), .WAIT_CYC(5), .SLEEP_CYC(3)) u_dut (
    .clk(clk), .rst(rst), .fill_level(fill_level), .fill_thresh(fill_thresh),
    .force_active(force_active), .host_valid(host_valid), .host_data(host_data),
    .host_ready(host_ready), .phy_tx_on(phy_tx_on), .phy_tx_marker(phy_tx_marker),
    .phy_tx_valid(phy_tx_valid), .phy_tx_data(phy_tx_data),
    .phy_rx_marker(phy_rx_marker), .phy_rx_idle_det(phy_rx_idle_det),
    .phy_rx_valid(phy_rx_valid), .phy_rx_data(phy_rx_data),
    .ctrl_rx_valid(ctrl_rx_valid), .ctrl_rx_data(ctrl_rx_data),
    .tx_state(tx_state), .rx_state(rx_state)
  );

  // fields: fill[13:8] force[7] rx_marker[6] rx_idle[5] exp_tx[4:2] exp_rx[1] exp_marker[0]
  localparam logic [13:0] VEC [0:19] = '{
    {6'd0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
    {6'd3,1'b0,1'b1,1'b0,3'd0,1'b1,1'b0},
    {6'd4,1'b0,1'b0,1'b0,3'd1,1'b1,1'b0},
    {6'd4,1'b0,1'b0,1'b0,3'd1,1'b1,1'b1},
    {6'd4,1'b0,1'b0,1'b0,3'd1,1'b1,1'b0},
    {6'd4,1'b0,1'b0,1'b0,3'd1,1'b1,1'b0},
    {6'd4,1'b0,1'b0,1'b0,3'd2,1'b1,1'b0},
    {6'd0,1'b0,1'b0,1'b1,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd2,1'b0,1'b0,1'b0,3'd2,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0},
    {6'd0,1'b0,1'b0,1'b0,3'd4,1'b0,1'b0},
    {6'd5,1'b0,1'b1,1'b0,3'd4,1'b1,1'b0},
    {6'd5,1'b0,1'b0,1'b0,3'd4,1'b1,1'b0},
    {6'd5,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0},
    {6'd5,1'b0,1'b0,1'b0,3'd1,1'b1,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    tick();
    tick();
    chk("R1 reset tx_state", 32'(tx_state), 0);
    chk("R1 reset rx_state", 32'(rx_state), 0);
    chk("R1 reset ready/on/marker", {host_ready, phy_tx_on, phy_tx_marker}, 0);
    chk("R1 reset valids", {phy_tx_valid, ctrl_rx_valid}, 0);
    rst = 1'b0;

    for (int i = 0; i < 20; i++) begin
      fill_level      = VEC[i][13:8];
      force_active    = VEC[i][7];
      phy_rx_marker   = VEC[i][6];
      phy_rx_idle_det = VEC[i][5];
      tick();
      chk($sformatf("R2/R5/R6 tx_state step %0d", i), 32'(tx_state), 32'(VEC[i][4:2]));
      chk($sformatf("R8/R10 rx_state step %0d", i), 32'(rx_state), 32'(VEC[i][1]));
      chk($sformatf("R3 marker step %0d", i), 32'(phy_tx_marker), 32'(VEC[i][0]));
      chk($sformatf("R3 phy_tx_on step %0d", i), 32'(phy_tx_on),
          32'(VEC[i][4:2] == 3'd1 || VEC[i][4:2] == 3'd2 || VEC[i][4:2] == 3'd3));
      chk($sformatf("R4 ready step %0d", i), 32'(host_ready), 32'(VEC[i][4:2] == 3'd2));
    end
    phy_rx_marker = 1'b0;
    phy_rx_idle_det = 1'b0;

    // R4: beats offered during resume are not taken
    host_valid = 1'b1;
    host_data  = 8'h3C;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R4 no beat while resuming", 32'(phy_tx_valid), 0);
    end
    chk("R3 active after resume window", 32'(tx_state), 2);
    tick();
    chk("R4 beat forwarded valid", 32'(phy_tx_valid), 1);
    chk("R4 beat forwarded data", 32'(phy_tx_data), 32'h3C);
    host_valid = 1'b0;
    tick();
    chk("R4 beat ends", 32'(phy_tx_valid), 0);

    // R5: data arriving on the last hold-off cycle wins over expiry
    fill_level = '0;
    tick();
    chk("R5 enter hold-off", 32'(tx_state), 3);
    for (int k = 0; k < 4; k++) tick();
    chk("R5 hold-off last cycle", 32'(tx_state), 3);
    fill_level = 6'd1;
    tick();
    chk("R5 arrival on last hold-off cycle keeps active", 32'(tx_state), 2);

    // R7: force keeps active with an empty buffer
    fill_level   = '0;
    force_active = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R7 forced active", 32'(tx_state), 2);
    end
    force_active = 1'b0;
    tick();
    chk("R7 release enters hold-off", 32'(tx_state), 3);
    for (int k = 0; k < 5; k++) tick();
    chk("R5 hold-off expiry enters idle entry", 32'(tx_state), 4);
    chk("R3 phy off during entry", 32'(phy_tx_on), 0);
    force_active = 1'b1;
    tick();
    chk("R7 force does not cut entry", 32'(tx_state), 4);
    tick();
    tick();
    chk("R6 entry completes to idle", 32'(tx_state), 0);
    tick();
    chk("R7 force wakes from idle", 32'(tx_state), 1);
    force_active = 1'b0;

    // R9: receive data gating
    phy_rx_idle_det = 1'b1;
    tick();
    chk("R8 rx idle on detect", 32'(rx_state), 0);
    phy_rx_idle_det = 1'b0;
    phy_rx_valid = 1'b1;
    phy_rx_data  = 8'h77;
    tick();
    chk("R9 rx beat dropped while idle", 32'(ctrl_rx_valid), 0);
    phy_rx_marker = 1'b1;
    tick();
    chk("R8 rx wakes on marker", 32'(rx_state), 1);
    chk("R9 marker-cycle beat dropped", 32'(ctrl_rx_valid), 0);
    phy_rx_marker = 1'b0;
    tick();
    chk("R9 rx beat forwarded valid", 32'(ctrl_rx_valid), 1);
    chk("R9 rx beat forwarded data", 32'(ctrl_rx_data), 32'h77);
    phy_rx_valid = 1'b0;

    // R1: reset during activity
    rst = 1'b1;
    tick();
    chk("R1 mid reset tx_state", 32'(tx_state), 0);
    chk("R1 mid reset rx_state", 32'(rx_state), 0);
    chk("R1 mid reset ready/on", {host_ready, phy_tx_on}, 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule